// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between a processor's request port and a cache controller and keeps a record of every memory request still in flight, indexed by cache-line address. Read-class requests (plain loads and instruction fetches) and write-class requests (stores, read-modify-write halves, linked loads, conditional stores, locked read-modify-write halves and flushes) live in two separate small fully associative tables. Each presented request gets an answer in the same cycle: accepted, aliased (the same line already has a request in flight), refused because the tracker is full, or rejected because the request kind is not supported.

Completion inputs, one for each table, carry a line address and free the matching entry. A line with no matching entry sets a sticky protocol-error flag. Each entry records the cycle it was issued. While anything is outstanding, a watchdog wakes up every threshold cycles and raises a sticky deadlock error if any entry's age has reached the threshold. After a deadlock error the request port stops accepting. Four counters record how often a request was turned away as aliased, split by which class was blocked by which.

Top module: `memreq_tracker`

## Requirements
- R1: If the occupancy is already at or above MAX_OUT when a request is presented, the status is FULL (code 2), whatever the kind or address, and no entry is written.
- R2: The request kind codes are: 0 load, 1 store, 2 RMW read, 3 RMW write, 4 linked load, 5 conditional store, 6 locked RMW read, 7 locked RMW write, 8 flush. Code 0 goes to the read table and codes 1 to 8 go to the write table. When the ifetch flag is 1 the request is an instruction fetch: it goes to the read table and its kind field is ignored. Without ifetch, codes 9 to 15 return BADKIND (code 3) and write no entry.
- R3: A write-class request whose line already has an entry in either table returns ALIAS (code 1) and writes no entry.
- R4: A read-class request whose line already has an entry in either table returns ALIAS (code 1) and writes no entry. Otherwise a supported request returns ACCEPT (code 0).
- R5: The occupancy output always equals the number of valid read entries plus the number of valid write entries. It rises by one on an accept and falls by one for each completion that matches an entry.
- R6: Four counters count aliased requests: a store blocked by a load, a store blocked by a store, a load blocked by a store, and a load blocked by a load. Each aliased response increments exactly one of them, and nothing else changes them.
- R7: The first accept while the watchdog is idle starts it. It then checks every THRESH cycles for as long as requests remain outstanding. If any entry's age at a check is THRESH cycles or more, the deadlock flag is set the next cycle, stays set until reset, and drives the ready output low.
- R8: The request address is reduced to its line address by dropping the low OFFW bits before lookup. An accepted entry blocks requests to the same line from the next cycle on. A read or write completion removes only the matching entry of its own table.
- R9: A completion whose line has no entry in its own table sets the sticky protocol-error flag and changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | Tracker accepts requests (low after a deadlock error) |
| req_addr | input | AW | Byte address of the request |
| req_kind | input | 4 | Request kind code (R2) |
| req_ifetch | input | 1 | Instruction fetch flag |
| rsp_valid | output | 1 | Status is valid this cycle (req_valid and req_ready) |
| rsp_status | output | 2 | 0 accept, 1 alias, 2 full, 3 bad kind |
| rd_done_valid | input | 1 | A read-class request completed |
| rd_done_line | input | AW-OFFW | Line address of the completed read |
| wr_done_valid | input | 1 | A write-class request completed |
| wr_done_line | input | AW-OFFW | Line address of the completed write |
| occupancy | output | clog2(MAX_OUT+1) | Number of outstanding requests |
| cnt_st_on_ld | output | CNTW | Stores aliased behind a load |
| cnt_st_on_st | output | CNTW | Stores aliased behind a store |
| cnt_ld_on_st | output | CNTW | Loads aliased behind a store |
| cnt_ld_on_ld | output | CNTW | Loads aliased behind a load |
| deadlock_err | output | 1 | Sticky watchdog error |
| proto_err | output | 1 | Sticky unmatched-completion error |

## Verification
The hardest case to reach is a watchdog check that finds an entry exactly one cycle short of the threshold. The test needs one request to start the watchdog, a second request placed one cycle later, and the first request completed. The first check then sees the second entry at age THRESH-1 and must stay quiet, and the following check must fire. The bench also sweeps every pair of first and second request kinds on one line, with different byte offsets, to cover each alias rule and each alias counter.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

   typedef enum logic [1:0] {
      ST_ACCEPT  = 2'd0,
      ST_ALIAS   = 2'd1,
      ST_FULL    = 2'd2,
      ST_BADKIND = 2'd3
   } mrt_status_e;

   localparam logic [3:0] KIND_LOAD     = 4'd0;
   localparam logic [3:0] KIND_LAST_OK  = 4'd8;

   function automatic logic kind_writes(input logic [3:0] kind, input logic ifetch);
      return !ifetch && (kind != KIND_LOAD);
   endfunction

   function automatic logic kind_known(input logic [3:0] kind, input logic ifetch);
      return ifetch || (kind <= KIND_LAST_OK);
   endfunction

endpackage

// File: rtl/mrt_line_table.sv
module mrt_line_table #(
   parameter int LW     = 8,
   parameter int DEPTH  = 4,
   parameter int TSW    = 6,
   parameter int THRESH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LW-1:0]    lk_line,
   output logic             lk_hit,
   input  logic             alloc_en,
   input  logic [LW-1:0]    alloc_line,
   input  logic [TSW-1:0]   now,
   input  logic             free_en,
   input  logic [LW-1:0]    free_line,
   output logic             free_hit,
   output logic             old_any,
   output logic [DEPTH-1:0] vld_o
);

   logic [DEPTH-1:0]           vld;
   logic [DEPTH-1:0][LW-1:0]   line;
   logic [DEPTH-1:0][TSW-1:0]  stamp;
   logic [DEPTH-1:0]           hitv, fhitv, oldv, pick;

   always_comb begin
      logic found;
      found = 1'b0;
      pick  = '0;
      for (int i = 0; i < DEPTH; i++) begin
         logic [TSW-1:0] age;
         age      = now - stamp[i];
         hitv[i]  = vld[i] && (line[i] == lk_line);
         fhitv[i] = vld[i] && (line[i] == free_line);
         oldv[i]  = vld[i] && (age >= TSW'(THRESH));
         if (!vld[i] && !found) begin
            pick[i] = 1'b1;
            found   = 1'b1;
         end
      end
   end

   assign lk_hit   = |hitv;
   assign free_hit = |fhitv;
   assign old_any  = |oldv;
   assign vld_o    = vld;

   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld[g]   <= 1'b0;
            line[g]  <= '0;
            stamp[g] <= '0;
         end else if (free_en && fhitv[g]) begin
            vld[g] <= 1'b0;
         end else if (alloc_en && pick[g]) begin
            vld[g]   <= 1'b1;
            line[g]  <= alloc_line;
            stamp[g] <= now;
         end
      end
   end

   // one entry per line: the alias rules never let a second copy in
   assert_one_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hitv));
   // an allocation only happens while a slot is free
   assert_slot_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> (vld != '1));
   // a freed line is gone on the next cycle
   assert_free_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (free_en && free_hit) |=> ($countones(vld) < $countones($past(vld)) + 1));

endmodule

// File: rtl/mrt_watchdog.sv
module mrt_watchdog #(
   parameter int THRESH = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_req,
   input  logic keep_going,
   output logic check_o
);

   localparam int TW = $clog2(THRESH + 1);

   logic          armed;
   logic [TW-1:0] timer;

   assign check_o = armed && (timer == TW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed <= 1'b0;
         timer <= '0;
      end else if (armed) begin
         if (timer == TW'(1)) begin
            if (keep_going) timer <= TW'(THRESH);
            else            armed <= 1'b0;
         end else begin
            timer <= timer - TW'(1);
         end
      end else if (arm_req) begin
         armed <= 1'b1;
         timer <= TW'(THRESH);
      end
   end

   assert_check_spaced_R7: assert property (@(posedge clk) disable iff (!rst_n)
      check_o |=> !check_o);

endmodule

// File: rtl/memreq_tracker.sv
module memreq_tracker #(
   parameter int AW      = 12,
   parameter int OFFW    = 4,
   parameter int MAX_OUT = 4,
   parameter int THRESH  = 16,
   parameter int CNTW    = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   output logic                        req_ready,
   input  logic [AW-1:0]               req_addr,
   input  logic [3:0]                  req_kind,
   input  logic                        req_ifetch,
   output logic                        rsp_valid,
   output logic [1:0]                  rsp_status,
   input  logic                        rd_done_valid,
   input  logic [AW-OFFW-1:0]          rd_done_line,
   input  logic                        wr_done_valid,
   input  logic [AW-OFFW-1:0]          wr_done_line,
   output logic [$clog2(MAX_OUT+1)-1:0] occupancy,
   output logic [CNTW-1:0]             cnt_st_on_ld,
   output logic [CNTW-1:0]             cnt_st_on_st,
   output logic [CNTW-1:0]             cnt_ld_on_st,
   output logic [CNTW-1:0]             cnt_ld_on_ld,
   output logic                        deadlock_err,
   output logic                        proto_err
);
   import mrt_pkg::*;

   localparam int LW  = AW - OFFW;
   localparam int CW  = $clog2(MAX_OUT + 1);
   localparam int TSW = $clog2(THRESH) + 2;

   initial begin
      assert (MAX_OUT >= 1) else $error("MAX_OUT must be at least 1");
      assert (THRESH >= 2) else $error("THRESH must be at least 2");
      assert (OFFW >= 0 && OFFW < AW) else $error("OFFW must leave line bits");
      assert (CNTW >= 1) else $error("CNTW must be positive");
   end

   logic [LW-1:0]   line;
   logic            fire, wcls, known, rd_hit, wr_hit, accept, aliased;
   logic            rd_fhit, wr_fhit, rd_old, wr_old, wd_check;
   logic            rd_free, wr_free;
   logic [CW-1:0]   cnt_q, cnt_nxt;
   logic [TSW-1:0]  now;
   logic            dl_q, pe_q;
   logic [MAX_OUT-1:0] rd_vld, wr_vld;
   mrt_status_e     status;
   logic [3:0]      inc;
   logic [3:0][CNTW-1:0] acnt;

   assign line  = req_addr[AW-1:OFFW];
   assign fire  = req_valid && req_ready;
   assign wcls  = kind_writes(req_kind, req_ifetch);
   assign known = kind_known(req_kind, req_ifetch);

   always_comb begin
      if (cnt_q >= CW'(MAX_OUT))  status = ST_FULL;
      else if (!known)            status = ST_BADKIND;
      else if (rd_hit || wr_hit)  status = ST_ALIAS;
      else                        status = ST_ACCEPT;
   end

   assign accept  = fire && (status == ST_ACCEPT);
   assign aliased = fire && (status == ST_ALIAS);

   // alias classification: 0 store/load, 1 store/store, 2 load/store, 3 load/load
   assign inc[0] = aliased &&  wcls &&  rd_hit;
   assign inc[1] = aliased &&  wcls && !rd_hit;
   assign inc[2] = aliased && !wcls &&  wr_hit;
   assign inc[3] = aliased && !wcls && !wr_hit;

   for (genvar g = 0; g < 4; g++) begin : g_acnt
      always_ff @(posedge clk) begin
         if (!rst_n)      acnt[g] <= '0;
         else if (inc[g]) acnt[g] <= acnt[g] + CNTW'(1);
      end
   end

   mrt_line_table #(.LW(LW), .DEPTH(MAX_OUT), .TSW(TSW), .THRESH(THRESH)) u_rd (
      .clk(clk), .rst_n(rst_n),
      .lk_line(line), .lk_hit(rd_hit),
      .alloc_en(accept && !wcls), .alloc_line(line), .now(now),
      .free_en(rd_done_valid), .free_line(rd_done_line), .free_hit(rd_fhit),
      .old_any(rd_old), .vld_o(rd_vld)
   );

   mrt_line_table #(.LW(LW), .DEPTH(MAX_OUT), .TSW(TSW), .THRESH(THRESH)) u_wr (
      .clk(clk), .rst_n(rst_n),
      .lk_line(line), .lk_hit(wr_hit),
      .alloc_en(accept && wcls), .alloc_line(line), .now(now),
      .free_en(wr_done_valid), .free_line(wr_done_line), .free_hit(wr_fhit),
      .old_any(wr_old), .vld_o(wr_vld)
   );

   assign rd_free = rd_done_valid && rd_fhit;
   assign wr_free = wr_done_valid && wr_fhit;
   assign cnt_nxt = cnt_q + CW'(accept) - CW'(rd_free) - CW'(wr_free);

   mrt_watchdog #(.THRESH(THRESH)) u_wd (
      .clk(clk), .rst_n(rst_n),
      .arm_req(accept), .keep_going(cnt_nxt != '0), .check_o(wd_check)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         now   <= '0;
         dl_q  <= 1'b0;
         pe_q  <= 1'b0;
      end else begin
         cnt_q <= cnt_nxt;
         now   <= now + TSW'(1);
         if (wd_check && (rd_old || wr_old))                        dl_q <= 1'b1;
         if ((rd_done_valid && !rd_fhit) || (wr_done_valid && !wr_fhit)) pe_q <= 1'b1;
      end
   end

   assign req_ready    = !dl_q;
   assign rsp_valid    = fire;
   assign rsp_status   = status;
   assign occupancy    = cnt_q;
   assign cnt_st_on_ld = acnt[0];
   assign cnt_st_on_st = acnt[1];
   assign cnt_ld_on_st = acnt[2];
   assign cnt_ld_on_ld = acnt[3];
   assign deadlock_err = dl_q;
   assign proto_err    = pe_q;

   assert_count_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q) == $countones(rd_vld) + $countones(wr_vld));
   assert_full_refused_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && (occupancy >= CW'(MAX_OUT))) |-> (rsp_status == 2'd2));
   assert_accept_grows_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status == 2'd0 && !rd_done_valid && !wr_done_valid)
         |=> (occupancy == $past(occupancy) + CW'(1)));
   assert_counters_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_valid && rsp_status == 2'd1)
         |=> ($stable(cnt_st_on_ld) && $stable(cnt_st_on_st) &&
              $stable(cnt_ld_on_st) && $stable(cnt_ld_on_ld)));
   assert_deadlock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      deadlock_err |=> (deadlock_err && !req_ready));
   assert_proto_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err);

endmodule

// File: tb/sim_memreq_tracker.sv
`timescale 1ns/1ps
module sim_memreq_tracker;

   localparam int AW = 12, OFFW = 4, MAXO = 4, TH = 16, CNTW = 16;
   localparam int LW = AW - OFFW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_ifetch = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [3:0] req_kind = '0;
   logic rd_done_valid = 1'b0, wr_done_valid = 1'b0;
   logic [LW-1:0] rd_done_line = '0, wr_done_line = '0;
   logic req_ready, rsp_valid, deadlock_err, proto_err;
   logic [1:0] rsp_status;
   logic [2:0] occupancy;
   logic [CNTW-1:0] c_sl, c_ss, c_ls, c_ll;

   int n_chk = 0, n_bad = 0;
   int e_sl = 0, e_ss = 0, e_ls = 0, e_ll = 0;

   always #5 clk = ~clk;

   memreq_tracker #(.AW(AW), .OFFW(OFFW), .MAX_OUT(MAXO), .THRESH(TH), .CNTW(CNTW)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_kind(req_kind), .req_ifetch(req_ifetch),
      .rsp_valid(rsp_valid), .rsp_status(rsp_status),
      .rd_done_valid(rd_done_valid), .rd_done_line(rd_done_line),
      .wr_done_valid(wr_done_valid), .wr_done_line(wr_done_line),
      .occupancy(occupancy), .cnt_st_on_ld(c_sl), .cnt_st_on_st(c_ss),
      .cnt_ld_on_st(c_ls), .cnt_ld_on_ld(c_ll),
      .deadlock_err(deadlock_err), .proto_err(proto_err)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
   endtask

   // presents one request for one cycle; returns the status seen before the edge
   task automatic issue(input logic [3:0] kind, input logic ifet, input logic [AW-1:0] addr,
                        output int st);
      @(negedge clk);
      req_valid = 1'b1; req_kind = kind; req_ifetch = ifet; req_addr = addr;
      #1 st = int'(rsp_status);
      @(posedge clk); #1;
      req_valid = 1'b0; req_ifetch = 1'b0;
   endtask

   task automatic done(input logic is_wr, input logic [LW-1:0] ln);
      @(negedge clk);
      if (is_wr) begin wr_done_valid = 1'b1; wr_done_line = ln; end
      else       begin rd_done_valid = 1'b1; rd_done_line = ln; end
      @(posedge clk); #1;
      rd_done_valid = 1'b0; wr_done_valid = 1'b0;
   endtask

   task automatic check_counters(input string req);
      check({req, " store-on-load"}, int'(c_sl), e_sl);
      check({req, " store-on-store"}, int'(c_ss), e_ss);
      check({req, " load-on-store"}, int'(c_ls), e_ls);
      check({req, " load-on-load"}, int'(c_ll), e_ll);
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int st;
      do_reset();
      #1;
      check("R5 reset occupancy", int'(occupancy), 0);
      check("R7 reset ready", int'(req_ready), 1);
      check("R7 reset deadlock", int'(deadlock_err), 0);
      check("R9 reset proto", int'(proto_err), 0);
      check_counters("R6 reset");

      // R2: every kind code on an empty tracker, with and without ifetch
      for (int k = 0; k < 16; k++) begin
         for (int f = 0; f < 2; f++) begin
            logic [LW-1:0] ln;
            int wr;
            ln = LW'(8'h40 + k);
            issue(4'(k), f[0], {ln, 4'h3}, st);
            if (f == 0 && k > 8) begin
               check("R2 unsupported kind", st, 3);
               check("R2 no entry for bad kind", int'(occupancy), 0);
            end else begin
               check("R2 supported kind accepted", st, 0);
               check("R5 occupancy after accept", int'(occupancy), 1);
               wr = (f == 0 && k != 0) ? 1 : 0;
               // completion on the other table must not remove it (R8)
               done(wr == 0, ln);
               check("R8 other table keeps entry", int'(occupancy), 1);
               done(wr != 0, ln);
               check("R8 own table frees entry", int'(occupancy), 0);
            end
         end
      end
      do_reset();

      // R3 R4 R6 R8: every ordered pair of kinds on one line, different byte offsets
      for (int k1 = 0; k1 < 9; k1++) begin
         for (int k2 = 0; k2 < 9; k2++) begin
            logic [LW-1:0] ln;
            int w1, w2;
            ln = LW'(k1 * 9 + k2);
            w1 = (k1 != 0); w2 = (k2 != 0);
            issue(4'(k1), 1'b0, {ln, 4'h0}, st);
            check("R4 first request accepted", st, 0);
            issue(4'(k2), 1'b0, {ln, 4'hF}, st);
            check(w2 ? "R3 write-class alias" : "R4 read-class alias", st, 1);
            if (w2 && !w1) e_sl++;
            else if (w2)   e_ss++;
            else if (w1)   e_ls++;
            else           e_ll++;
            check_counters("R6 alias counter");
            check("R5 alias adds no entry", int'(occupancy), 1);
            issue(4'(k2), 1'b0, {ln + LW'(1), 4'h7}, st);
            check("R8 neighbour line accepted", st, 0);
            done(w1 != 0, ln);
            done(w2 != 0, ln + LW'(1));
            check("R5 drained", int'(occupancy), 0);
         end
      end
      check("R9 no spurious proto error", int'(proto_err), 0);
      check("R7 no spurious deadlock", int'(deadlock_err), 0);

      // R1: fill, refuse, free one, accept again
      for (int i = 0; i < MAXO; i++) begin
         issue(4'(i % 2), 1'b0, {LW'(8'hA0 + i), 4'h0}, st);
         check("R1 fill accepted", st, 0);
      end
      check("R5 full occupancy", int'(occupancy), MAXO);
      issue(4'd0, 1'b0, {LW'(8'hB0), 4'h0}, st);
      check("R1 full refuses", st, 2);
      issue(4'd12, 1'b0, {LW'(8'hA0), 4'h0}, st);
      check("R1 full beats bad kind and alias", st, 2);
      check("R1 refusal adds no entry", int'(occupancy), MAXO);
      done(1'b1, LW'(8'hA1));
      issue(4'd1, 1'b0, {LW'(8'hB0), 4'h0}, st);
      check("R1 accepted after free", st, 0);
      done(1'b0, LW'(8'hA0));
      done(1'b0, LW'(8'hA2));
      done(1'b1, LW'(8'hA3));
      done(1'b1, LW'(8'hB0));
      check("R5 empty again", int'(occupancy), 0);

      // R9: unmatched completion
      issue(4'd0, 1'b0, {LW'(8'h11), 4'h0}, st);
      done(1'b1, LW'(8'h11));
      check("R9 unmatched completion flags", int'(proto_err), 1);
      check("R9 entry untouched", int'(occupancy), 1);
      done(1'b0, LW'(8'h11));
      check("R9 flag is sticky", int'(proto_err), 1);
      check("R5 after proto test", int'(occupancy), 0);
      do_reset();
      #1 check("R9 cleared by reset", int'(proto_err), 0);

      // R7: entry one short of the threshold at the first check
      issue(4'd0, 1'b0, {LW'(8'h21), 4'h0}, st);   // starts watchdog
      issue(4'd1, 1'b0, {LW'(8'h22), 4'h0}, st);   // one cycle younger
      done(1'b0, LW'(8'h21));
      repeat (14) @(posedge clk);
      #1 check("R7 age THRESH-1 not flagged", int'(deadlock_err), 0);
      repeat (15) @(posedge clk);
      #1 check("R7 not flagged before second check", int'(deadlock_err), 0);
      @(posedge clk);
      #1 check("R7 flagged at second check", int'(deadlock_err), 1);
      check("R7 ready drops", int'(req_ready), 0);
      repeat (3) @(posedge clk);
      #1 check("R7 deadlock sticky", int'(deadlock_err), 1);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule